// File: doc/BRIEF.md
# Write-back write-allocate cache

This block is a very small fully associative cache with two lines. It sits between a processor that issues byte loads and stores and a word-wide backing memory. Each line holds two words, and each word is one byte. A store changes only the cached copy and marks the line dirty. Memory is written only when a dirty line has to leave the cache: on a miss that evicts it, or during a flush. In that case both words of the line go back to memory before the new block is read, so memory is updated in order.

Both ports use a valid/ready handshake. The processor holds `cpu_valid` and its request fields steady until it sees `cpu_ready` high for one cycle. `cpu_rdata` is valid in that cycle for a load. The cache holds `mem_valid` and the request fields steady until `mem_ready` is high. In a read cycle that completes, `mem_rdata` must carry the addressed word. A 4-bit byte address splits into a tag, `addr[3:1]`, and a word select, `addr[0]`. The memory word address for word w of a block with tag t is `{t, w}`.

A flush request walks both lines. It writes back the dirty ones, invalidates everything and then pulses `flush_done`. Three counters report hits, misses and dirty write-backs.

Top module: `wb_cache`

## Requirements
- R1: While reset is held and right after it, all counters read 0 and `cpu_ready`, `mem_valid` and `flush_done` are low. Both lines start invalid, so the first access misses.
- R2: A load hit returns the byte most recently stored to that address. It causes no memory transfer and adds 1 to `hit_count`. With `cpu_ready` low beforehand, `cpu_ready` is high in the second cycle after the edge that accepts the request.
- R3: A store hit writes only the cache, with no memory write. Later loads return the new byte.
- R4: A miss whose victim is invalid or clean adds 1 to `miss_count`. It performs no memory write and reads word addresses `{tag,0}` then `{tag,1}`. With a memory that never stalls, `cpu_ready` rises four cycles after acceptance.
- R5: A miss whose victim is dirty first writes `{victim_tag,0}` and then `{victim_tag,1}` with the line's current bytes. No read starts before both writes are done. The miss adds 1 to `evict_count`. With a memory that never stalls, `cpu_ready` rises six cycles after acceptance.
- R6: A store miss first fills the block from memory and then applies the byte. The line becomes dirty, so its later eviction writes the stored byte back.
- R7: The victim is line 0 if line 0 is invalid, else line 1 if line 1 is invalid, else the least recently used line. Every hit and every fill makes the line it uses the most recently used.
- R8: A request on `flush_req` writes back every dirty line (two word writes each, each line counted in `evict_count`). It does no reads and leaves both lines invalid. It then raises `flush_done` for exactly one cycle. A flush with no dirty line writes nothing.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and (for writes) `mem_wdata` hold their values. Memory stall cycles delay results but never change them.
- R10: On an empty cache, the sequence load 1, load 7, store 0, store 5, load 10, store 5, store 10 ends with 3 hits, 4 misses, 8 word reads, 2 word writes and 1 dirty eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | TAG_W+OFF_W | Byte address |
| cpu_wdata | input | DATA_W | Store byte |
| cpu_rdata | output | DATA_W | Load byte, valid with cpu_ready |
| mem_valid | output | 1 | Memory word request present |
| mem_ready | input | 1 | Memory accepts or returns the word this cycle |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | TAG_W+OFF_W | Memory word address {tag, word} |
| mem_wdata | output | DATA_W | Word written back |
| mem_rdata | input | DATA_W | Word read, valid in the completing cycle |
| flush_req | input | 1 | Write back and invalidate all lines |
| flush_done | output | 1 | One-cycle pulse when the flush is complete |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| evict_count | output | CNT_W | Number of dirty-line write-backs |

## Verification
With a memory that never stalls, a load or store completes two cycles after the accepting edge on a hit and four cycles after it on a clean miss. A miss that evicts a dirty line takes six cycles. Every memory stall cycle adds one. The counters settle at the tag-compare edge, one edge after acceptance. The bench drives inputs on falling edges and polls `cpu_ready` and `flush_done` on falling edges, so each latency is counted in whole cycles. It reads the counters and its own memory-transfer log only after the completing cycle has been seen, when every update of that operation has already happened. Expected hit, miss and write-back outcomes come from a small model of the tags and LRU kept in the bench. Expected data comes from a flat record of the latest byte stored at each address. After every flush, the backing memory is compared with that record.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  // Two lines: the replacement state is a single bit naming the older line.
  localparam int LINES = 2;
  localparam int WAY_W = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_APPLY, S_FSCAN, S_FWB, S_FDONE
  } state_t;

  // Invalid lines are taken first, lowest index first; otherwise the older line.
  function automatic logic [WAY_W-1:0] pick_victim(input logic [LINES-1:0] valid,
                                                    input logic [WAY_W-1:0] lru);
    if (!valid[0]) return 1'b0;
    if (!valid[1]) return 1'b1;
    return lru;
  endfunction

  // After a line is used, the other one becomes the replacement candidate.
  function automatic logic [WAY_W-1:0] lru_after(input logic [WAY_W-1:0] used);
    return ~used;
  endfunction
endpackage

// File: rtl/wbc_meta.sv
module wbc_meta
  import wbc_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        dirty_en,
  input  logic [WAY_W-1:0]            dirty_way,
  input  logic                        inval_en,
  input  logic [WAY_W-1:0]            inval_way,
  input  logic                        touch_en,
  input  logic [WAY_W-1:0]            touch_way,
  output logic [LINES-1:0]            valid,
  output logic [LINES-1:0]            dirty,
  output logic [LINES-1:0][TAG_W-1:0] tags,
  output logic [WAY_W-1:0]            lru
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      dirty <= '0;
      tags  <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (inval_en && inval_way == WAY_W'(i)) begin
          valid[i] <= 1'b0;
          dirty[i] <= 1'b0;
        end else if (fill_en && fill_way == WAY_W'(i)) begin
          valid[i] <= 1'b1;
          dirty[i] <= 1'b0;
          tags[i]  <= fill_tag;
        end else if (dirty_en && dirty_way == WAY_W'(i)) begin
          dirty[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru <= '0;
    else if (touch_en) lru <= lru_after(touch_way);
  end
endmodule

// File: rtl/wbc_data.sv
module wbc_data
  import wbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 1 << OFF_W;

  logic [DATA_W-1:0] store_q [LINES][WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++)
        for (int w = 0; w < WORDS; w++)
          store_q[l][w] <= '0;
    end else if (wr_en) begin
      store_q[wr_way][wr_off] <= wr_data;
    end
  end

  assign rd_data = store_q[rd_way][rd_off];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_valid,
  input  logic                        cpu_we,
  input  logic [TAG_W+OFF_W-1:0]      cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  output logic                        cpu_ready,
  output logic [DATA_W-1:0]           cpu_rdata,
  output logic                        mem_valid,
  input  logic                        mem_ready,
  output logic                        mem_we,
  output logic [TAG_W+OFF_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  input  logic                        flush_req,
  output logic                        flush_done,
  input  logic [LINES-1:0]            valid,
  input  logic [LINES-1:0]            dirty,
  input  logic [LINES-1:0][TAG_W-1:0] tags,
  input  logic [WAY_W-1:0]            lru,
  output logic                        fill_en,
  output logic [TAG_W-1:0]            fill_tag,
  output logic                        dirty_en,
  output logic                        inval_en,
  output logic [WAY_W-1:0]            inval_way,
  output logic                        touch_en,
  output logic [WAY_W-1:0]            way_sel,
  output logic                        dwr_en,
  output logic [OFF_W-1:0]            dwr_off,
  output logic [DATA_W-1:0]           dwr_data,
  output logic [OFF_W-1:0]            drd_off,
  input  logic [DATA_W-1:0]           drd_data,
  output logic                        ev_hit,
  output logic                        ev_miss,
  output logic                        ev_dirty_evict,
  output logic [CNT_W-1:0]            hit_count,
  output logic [CNT_W-1:0]            miss_count,
  output logic [CNT_W-1:0]            evict_count
);
  localparam int ADDR_W = TAG_W + OFF_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);
  localparam logic [WAY_W-1:0] LAST_WAY  = WAY_W'(LINES - 1);

  state_t              state;
  logic                req_we;
  logic [ADDR_W-1:0]   req_addr;
  logic [DATA_W-1:0]   req_wdata;
  logic [WAY_W-1:0]    way_r;
  logic [OFF_W-1:0]    beat;
  logic [WAY_W-1:0]    fl_idx;

  logic [TAG_W-1:0]    req_tag;
  logic [OFF_W-1:0]    req_off;
  logic [LINES-1:0]    hit_vec;
  logic                hit;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    victim;
  logic                victim_dirty;
  logic                scan_dirty;
  logic                xfer;
  logic                last_beat;
  logic                fl_last;
  logic                in_wb;

  assign req_tag = req_addr[ADDR_W-1:OFF_W];
  assign req_off = req_addr[OFF_W-1:0];

  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (tags[i] == req_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < LINES; i++)
      if (hit_vec[i]) hit_way = WAY_W'(i);
  end

  assign hit          = |hit_vec;
  assign victim       = pick_victim(valid, lru);
  assign victim_dirty = valid[victim] && dirty[victim];
  assign scan_dirty   = valid[fl_idx] && dirty[fl_idx];
  assign in_wb        = (state == S_WB) || (state == S_FWB);
  assign xfer         = mem_valid && mem_ready;
  assign last_beat    = (beat == LAST_BEAT);
  assign fl_last      = (fl_idx == LAST_WAY);

  assign ev_hit         = (state == S_LOOK) && hit;
  assign ev_miss        = (state == S_LOOK) && !hit;
  assign ev_dirty_evict = (ev_miss && victim_dirty) || ((state == S_FSCAN) && scan_dirty);

  // Memory side
  assign mem_valid = in_wb || (state == S_FILL);
  assign mem_we    = in_wb;
  assign mem_addr  = (state == S_FILL) ? {req_tag, beat} : {tags[way_r], beat};
  assign mem_wdata = in_wb ? drd_data : '0;

  // Processor side
  assign cpu_ready  = (state == S_APPLY);
  assign cpu_rdata  = cpu_ready ? drd_data : '0;
  assign flush_done = (state == S_FDONE);

  // Line storage commands
  assign way_sel  = way_r;
  assign drd_off  = (state == S_APPLY) ? req_off : beat;
  assign dwr_en   = ((state == S_FILL) && xfer) || ((state == S_APPLY) && req_we);
  assign dwr_off  = (state == S_FILL) ? beat : req_off;
  assign dwr_data = (state == S_FILL) ? mem_rdata : req_wdata;
  assign fill_en  = (state == S_FILL) && xfer && last_beat;
  assign fill_tag = req_tag;
  assign dirty_en = (state == S_APPLY) && req_we;
  assign touch_en = (state == S_APPLY);

  always_comb begin
    inval_en  = 1'b0;
    inval_way = way_r;
    if (ev_miss && valid[victim] && !dirty[victim]) begin
      inval_en  = 1'b1;
      inval_way = victim;
    end else if (in_wb && xfer && last_beat) begin
      inval_en  = 1'b1;
      inval_way = way_r;
    end else if ((state == S_FSCAN) && !scan_dirty) begin
      inval_en  = 1'b1;
      inval_way = fl_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      req_we      <= 1'b0;
      req_addr    <= '0;
      req_wdata   <= '0;
      way_r       <= '0;
      beat        <= '0;
      fl_idx      <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
      evict_count <= '0;
    end else begin
      if (ev_hit)         hit_count   <= hit_count + 1'b1;
      if (ev_miss)        miss_count  <= miss_count + 1'b1;
      if (ev_dirty_evict) evict_count <= evict_count + 1'b1;
      case (state)
        S_IDLE: begin
          if (flush_req) begin
            fl_idx <= '0;
            state  <= S_FSCAN;
          end else if (cpu_valid) begin
            req_we    <= cpu_we;
            req_addr  <= cpu_addr;
            req_wdata <= cpu_wdata;
            state     <= S_LOOK;
          end
        end
        S_LOOK: begin
          beat <= '0;
          if (hit) begin
            way_r <= hit_way;
            state <= S_APPLY;
          end else begin
            way_r <= victim;
            state <= victim_dirty ? S_WB : S_FILL;
          end
        end
        S_WB: begin
          if (xfer) begin
            beat <= last_beat ? '0 : beat + 1'b1;
            if (last_beat) state <= S_FILL;
          end
        end
        S_FILL: begin
          if (xfer) begin
            beat <= last_beat ? '0 : beat + 1'b1;
            if (last_beat) state <= S_APPLY;
          end
        end
        S_APPLY: state <= S_IDLE;
        S_FSCAN: begin
          way_r <= fl_idx;
          beat  <= '0;
          if (scan_dirty)   state  <= S_FWB;
          else if (fl_last) state  <= S_FDONE;
          else              fl_idx <= fl_idx + 1'b1;
        end
        S_FWB: begin
          if (xfer) begin
            beat <= last_beat ? '0 : beat + 1'b1;
            if (last_beat) begin
              if (fl_last) state <= S_FDONE;
              else begin
                fl_idx <= fl_idx + 1'b1;
                state  <= S_FSCAN;
              end
            end
          end
        end
        S_FDONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wbc_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  output logic                   cpu_ready,
  input  logic                   cpu_we,
  input  logic [TAG_W+OFF_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic                   mem_we,
  output logic [TAG_W+OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   flush_req,
  output logic                   flush_done,
  output logic [CNT_W-1:0]       hit_count,
  output logic [CNT_W-1:0]       miss_count,
  output logic [CNT_W-1:0]       evict_count
);
  // Named internal events, also observed by the bound checker.
  logic                        ev_hit;
  logic                        ev_miss;
  logic                        ev_dirty_evict;
  logic [LINES-1:0]            line_valid;
  logic [LINES-1:0]            line_dirty;
  logic [LINES-1:0][TAG_W-1:0] line_tags;
  logic [WAY_W-1:0]            lru;

  logic                        fill_en, dirty_en, inval_en, touch_en, dwr_en;
  logic [TAG_W-1:0]            fill_tag;
  logic [WAY_W-1:0]            inval_way, way_sel;
  logic [OFF_W-1:0]            dwr_off, drd_off;
  logic [DATA_W-1:0]           dwr_data, drd_data;

  wbc_meta #(.TAG_W(TAG_W)) u_meta (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_way(way_sel), .fill_tag(fill_tag),
    .dirty_en(dirty_en), .dirty_way(way_sel),
    .inval_en(inval_en), .inval_way(inval_way),
    .touch_en(touch_en), .touch_way(way_sel),
    .valid(line_valid), .dirty(line_dirty), .tags(line_tags), .lru(lru)
  );

  wbc_data #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dwr_en), .wr_way(way_sel), .wr_off(dwr_off), .wr_data(dwr_data),
    .rd_way(way_sel), .rd_off(drd_off), .rd_data(drd_data)
  );

  wbc_ctrl #(.TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .flush_req(flush_req), .flush_done(flush_done),
    .valid(line_valid), .dirty(line_dirty), .tags(line_tags), .lru(lru),
    .fill_en(fill_en), .fill_tag(fill_tag), .dirty_en(dirty_en),
    .inval_en(inval_en), .inval_way(inval_way), .touch_en(touch_en), .way_sel(way_sel),
    .dwr_en(dwr_en), .dwr_off(dwr_off), .dwr_data(dwr_data),
    .drd_off(drd_off), .drd_data(drd_data),
    .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_dirty_evict(ev_dirty_evict),
    .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count)
  );
endmodule

// File: rtl/wb_cache_chk.sv
module wb_cache_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int LINES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              cpu_ready,
  input logic              flush_done,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic              ev_hit,
  input logic              ev_miss,
  input logic              ev_dirty_evict,
  input logic [LINES-1:0]  line_valid,
  input logic [LINES-1:0]  line_dirty
);
  // A read has completed in the current access; cleared when the access finishes.
  logic rd_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 rd_seen <= 1'b0;
    else if (cpu_ready)                         rd_seen <= 1'b0;
    else if (mem_valid && mem_ready && !mem_we) rd_seen <= 1'b1;
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && (!mem_we || $stable(mem_wdata)));

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> !mem_valid);

  // R2
  cpu_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid);

  // R5
  wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> !rd_seen);

  // R4
  clean_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss && !ev_dirty_evict |=> mem_valid && !mem_we);

  // R4
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1);

  // R2
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count == $past(hit_count) || hit_count == $past(hit_count) + 1'b1);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> line_valid == '0 && line_dirty == '0);
endmodule

bind wb_cache wb_cache_chk #(
  .ADDR_W(TAG_W + OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LINES(wbc_pkg::LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .cpu_ready(cpu_ready), .flush_done(flush_done),
  .hit_count(hit_count), .miss_count(miss_count),
  .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_dirty_evict(ev_dirty_evict),
  .line_valid(line_valid), .line_dirty(line_dirty)
);

// File: tb/wb_cache_tb.sv
module wb_cache_tb;
  localparam int TAG_W  = 3;
  localparam int OFF_W  = 1;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = TAG_W + OFF_W;
  localparam int NADDR  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_valid, mem_we;
  logic              mem_ready = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              flush_req = 1'b0;
  logic              flush_done;
  logic [CNT_W-1:0]  hit_count, miss_count, evict_count;

  wb_cache #(.TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .flush_req(flush_req), .flush_done(flush_done),
    .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count)
  );

  // Backing memory and the architectural record of the latest byte per address.
  logic [DATA_W-1:0] bmem [NADDR];
  logic [DATA_W-1:0] arch [NADDR];
  assign mem_rdata = bmem[mem_addr];

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int log_n = 0;
  logic              log_we   [8];
  logic [ADDR_W-1:0] log_addr [8];
  bit   stall_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  bit   finished = 1'b0;

  // Memory model: decides ready for the coming edge, then records the transfer.
  always @(negedge clk) begin
    if (stall_on) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = (lfsr[1:0] != 2'b00);
    end else begin
      mem_ready = 1'b1;
    end
    if (mem_valid && mem_ready) begin
      if (log_n < 8) begin
        log_we[log_n]   = mem_we;
        log_addr[log_n] = mem_addr;
        log_n++;
      end
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        rd_cnt++;
      end
    end
  end

  // Bench model of tags and replacement, written from the requirements.
  bit       m_valid [2];
  bit       m_dirty [2];
  int       m_tag   [2];
  int       m_lru = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic op(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                    input string req);
    int tag, way, vic, vtag, lat, h0, m0, e0, r0, w0, exp_lat, exp_n;
    bit hit, dev, ord_ok;
    logic [DATA_W-1:0] rd, exp_rd;
    tag = addr >> OFF_W;
    hit = 0; way = 0;
    for (int i = 0; i < 2; i++)
      if (m_valid[i] && m_tag[i] == tag) begin hit = 1; way = i; end
    vic = !m_valid[0] ? 0 : (!m_valid[1] ? 1 : m_lru);
    dev = !hit && m_valid[vic] && m_dirty[vic];
    vtag = m_tag[vic];
    exp_rd = arch[addr];
    h0 = int'(hit_count); m0 = int'(miss_count); e0 = int'(evict_count);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    log_n = 0;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ready && lat < 2000);
    rd = cpu_rdata;
    cpu_valid = 1'b0;
    if (!we) check(rd == exp_rd, req, "load data", int'(rd), int'(exp_rd));
    check(int'(hit_count) - h0 == (hit ? 1 : 0), req, "hit count step", int'(hit_count) - h0, hit ? 1 : 0);
    check(int'(miss_count) - m0 == (hit ? 0 : 1), req, "miss count step", int'(miss_count) - m0, hit ? 0 : 1);
    check(int'(evict_count) - e0 == (dev ? 1 : 0), req, "evict count step", int'(evict_count) - e0, dev ? 1 : 0);
    check(rd_cnt - r0 == (hit ? 0 : 2), req, "word reads", rd_cnt - r0, hit ? 0 : 2);
    check(wr_cnt - w0 == (dev ? 2 : 0), req, "word writes", wr_cnt - w0, dev ? 2 : 0);
    if (!stall_on) begin
      exp_lat = hit ? 2 : (dev ? 6 : 4);
      check(lat == exp_lat, req, "latency", lat, exp_lat);
    end
    if (!hit) begin
      exp_n = dev ? 4 : 2;
      ord_ok = (log_n == exp_n);
      if (ord_ok) begin
        for (int k = 0; k < exp_n; k++) begin
          if (dev && k < 2) ord_ok &= log_we[k] && int'(log_addr[k]) == vtag * 2 + k;
          else              ord_ok &= !log_we[k] && int'(log_addr[k]) == tag * 2 + (k % 2);
        end
      end
      check(ord_ok, req, "memory transfer order", log_n, exp_n);
      m_valid[vic] = 1; m_dirty[vic] = 0; m_tag[vic] = tag; way = vic;
    end
    if (we) begin
      m_dirty[way] = 1;
      arch[addr] = wd;
    end
    m_lru = 1 - way;
  endtask

  task automatic do_flush(input string req);
    int exp_w, ndirty, w0, r0, e0, n, bad;
    ndirty = 0;
    for (int i = 0; i < 2; i++) if (m_valid[i] && m_dirty[i]) ndirty++;
    exp_w = 2 * ndirty;
    w0 = wr_cnt; r0 = rd_cnt; e0 = int'(evict_count);
    @(negedge clk);
    flush_req = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!flush_done && n < 2000);
    check(flush_done, req, "flush done seen", int'(flush_done), 1);
    flush_req = 1'b0;
    @(negedge clk);
    check(!flush_done, req, "flush done one cycle", int'(flush_done), 0);
    check(wr_cnt - w0 == exp_w, req, "flush word writes", wr_cnt - w0, exp_w);
    check(rd_cnt == r0, req, "flush word reads", rd_cnt - r0, 0);
    check(int'(evict_count) - e0 == ndirty, req, "flush evict count", int'(evict_count) - e0, ndirty);
    for (int i = 0; i < 2; i++) begin m_valid[i] = 0; m_dirty[i] = 0; end
    bad = 0;
    for (int a = 0; a < NADDR; a++) if (bmem[a] !== arch[a]) bad++;
    check(bad == 0, req, "memory matches stored bytes", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int h0, m0, e0, r0, w0;
    int seed;
    for (int a = 0; a < NADDR; a++) begin
      bmem[a] = DATA_W'(a * 37 + 11);
      arch[a] = DATA_W'(a * 37 + 11);
    end
    for (int i = 0; i < 2; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; end

    // R1: state during and after reset
    repeat (2) @(negedge clk);
    check(hit_count == 0 && miss_count == 0 && evict_count == 0, "R1", "counters in reset",
          int'(hit_count) + int'(miss_count) + int'(evict_count), 0);
    check(!cpu_ready && !mem_valid && !flush_done, "R1", "outputs idle in reset",
          int'(cpu_ready) + int'(mem_valid) + int'(flush_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!cpu_ready && !mem_valid && !flush_done, "R1", "outputs idle after reset",
          int'(cpu_ready) + int'(mem_valid) + int'(flush_done), 0);
    check(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
          int'(hit_count) + int'(miss_count), 0);

    // R10: reference sequence on an empty cache
    h0 = int'(hit_count); m0 = int'(miss_count); e0 = int'(evict_count);
    r0 = rd_cnt; w0 = wr_cnt;
    op(0, 1,  8'h00, "R10");
    op(0, 7,  8'h00, "R10");
    op(1, 0,  8'hC3, "R10");
    op(1, 5,  8'h3C, "R10");
    op(0, 10, 8'h00, "R10");
    op(1, 5,  8'h77, "R10");
    op(1, 10, 8'h99, "R10");
    check(int'(hit_count) - h0 == 3, "R10", "total hits", int'(hit_count) - h0, 3);
    check(int'(miss_count) - m0 == 4, "R10", "total misses", int'(miss_count) - m0, 4);
    check(rd_cnt - r0 == 8, "R10", "total word reads", rd_cnt - r0, 8);
    check(wr_cnt - w0 == 2, "R10", "total word writes", wr_cnt - w0, 2);
    check(int'(evict_count) - e0 == 1, "R10", "dirty evictions", int'(evict_count) - e0, 1);

    // R8: flush with two dirty lines, then with none
    do_flush("R8");
    do_flush("R8");

    // R7: invalid lines first, then least recently used
    op(0, 2, 8'h00, "R7");
    op(0, 4, 8'h00, "R7");
    op(0, 3, 8'h00, "R7");
    op(0, 5, 8'h00, "R7");
    op(0, 2, 8'h00, "R7");
    op(0, 6, 8'h00, "R7");
    op(0, 2, 8'h00, "R7");
    op(0, 4, 8'h00, "R7");

    // R3: store hits, then read back
    op(1, 4, 8'hA1, "R3");
    op(1, 5, 8'hB2, "R3");
    op(0, 4, 8'h00, "R3");
    op(0, 5, 8'h00, "R3");

    // R6: store misses allocate and dirty their lines
    op(1, 9,  8'h5E, "R6");
    op(1, 14, 8'h6F, "R6");
    op(0, 0,  8'h00, "R6");
    op(0, 2,  8'h00, "R6");
    op(0, 9,  8'h00, "R6");
    do_flush("R6");

    // R2 R4 R5: sweep every address with stores, then loads in two orders
    for (int a = 0; a < NADDR; a++) op(1, a, DATA_W'(a ^ 8'h5A), "R5");
    for (int a = 0; a < NADDR; a++) op(0, a, 8'h00, "R2");
    for (int a = NADDR - 1; a >= 0; a--) op(0, a, 8'h00, "R4");
    do_flush("R5");

    // R9: memory stalls with a pseudo-random mix of loads and stores
    stall_on = 1'b1;
    seed = 12345;
    for (int k = 0; k < 400; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      op(((seed >> 8) & 3) == 0, (seed >> 12) % NADDR, DATA_W'(seed >> 20), "R9");
    end
    do_flush("R9");
    stall_on = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule